// File: doc/BRIEF.md
# Masked-Write GPIO Bank

This block is a 32-pin general-purpose I/O bank behind a small 32-bit register bus. Software sets each pin's direction and output level. It reads back the current pin levels through a synchronized input register. Pin n corresponds to bit n of every 32-bit logical register.

The output-level register and the direction register are each split into two 16-bit halves. The low half covers pins 0 to 15 and the high half covers pins 16 to 31. Every write to a half carries data in bits [15:0] and a per-bit enable in bits [31:16]. Only the data bits whose enable bit is set change. Software can therefore flip a single pin without a read-modify-write sequence, so two agents cannot overwrite each other's change.

Word addresses:

| Address | Register |
|---|---|
| 0 | Output level, pins 0 to 15 |
| 1 | Output level, pins 16 to 31 |
| 2 | Direction, pins 0 to 15 |
| 3 | Direction, pins 16 to 31 |
| 4 | Synchronized pin levels, all 32 pins, read-only |

Addresses 5 to 7 are unmapped. Read data is combinational: it is valid in the same cycle as `rd_en_i`.

Top module: `gpio_bank`

## Requirements
- R1: After reset, every output-level bit and every direction bit is 0. As a result, `pin_oe_o` and `pin_o` are all zero.
- R2: A write to a half register updates data bit i only when bit 16+i of `wdata_i` is 1. Bits whose enable is 0 keep their value. A write with an all-zero enable changes nothing.
- R3: A write whose enable field is 0xFFFF loads all 16 data bits of the addressed half.
- R4: Addresses 0 and 2 control pins 0 to 15 only. Addresses 1 and 3 control pins 16 to 31 only. A write to one half never changes the other half.
- R5: `pin_oe_o[n]` equals direction bit n. `pin_o[n]` equals output-level bit n, whatever the direction.
- R6: A read of addresses 0 to 3 returns the 16 stored bits in [15:0] and 0 in [31:16].
- R7: A read of address 4 returns `pin_i` after a two-flop synchronizer. A level applied before a clock edge is not visible after that first edge. It is visible after the second edge.
- R8: Writes to address 4 and to addresses 5 to 7 change no state. Reads of addresses 5 to 7 return 0.
- R9: `rdata_o` is 0 whenever `rd_en_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe, one cycle per write |
| rd_en_i | input | 1 | Read enable |
| addr_i | input | 3 | Word address |
| wdata_i | input | 32 | Write data: [31:16] enable, [15:0] data |
| rdata_o | output | 32 | Read data |
| pin_i | input | 32 | Sampled pin levels |
| pin_o | output | 32 | Pin output levels |
| pin_oe_o | output | 32 | Pin output enables |

## Verification
The hardest situation to reach from the ports is a partial-enable write that lands on a half already holding a mixed pattern. The result only distinguishes a correct merge from a plain load, or from a merge that used the wrong half, if both the cleared bits and the kept bits are visible.

The stimulus first loads a non-uniform value with a full enable. It then applies two partial writes whose enable fields overlap set and clear bits. It then writes the opposite half and confirms that the first half is unchanged.

The synchronizer delay is checked by reading the pin register between the first and second edges after a pin change.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int HALF_W     = 16;
  localparam int NUM_HALVES = 2;
  localparam int NUM_PINS   = HALF_W * NUM_HALVES;
  localparam int BUS_W      = 32;
  localparam int ADDR_W     = 3;
  localparam int OUT_BASE   = 0;
  localparam int DIR_BASE   = OUT_BASE + NUM_HALVES;
  localparam int PIN_ADDR   = DIR_BASE + NUM_HALVES;
endpackage

// File: rtl/gpio_mask_reg.sv
module gpio_mask_reg #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic [W-1:0] wmask_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= '0;
    else if (wr_i) q_q <= (q_q & ~wmask_i) | (wdata_i & wmask_i);
  end

  assign q_o = q_q;

  // R2
  keep_unmasked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> ((q_q & ~$past(wmask_i)) == ($past(q_q) & ~$past(wmask_i))));

  // R2
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(q_q));

  // R3
  masked_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> ((q_q & $past(wmask_i)) == ($past(wdata_i) & $past(wmask_i))));
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BUS_W-1:0]  wdata_i,
  output logic [BUS_W-1:0]  rdata_o,
  input  logic [NUM_PINS-1:0] pin_i,
  output logic [NUM_PINS-1:0] pin_o,
  output logic [NUM_PINS-1:0] pin_oe_o
);
  logic [NUM_PINS-1:0] out_q, dir_q, pin_sync;
  logic [HALF_W-1:0]   wr_data, wr_mask;

  assign wr_data = wdata_i[HALF_W-1:0];
  assign wr_mask = wdata_i[2*HALF_W-1:HALF_W];

  for (genvar h = 0; h < NUM_HALVES; h++) begin : g_half
    logic wr_out, wr_dir;
    assign wr_out = wr_en_i && (addr_i == ADDR_W'(OUT_BASE + h));
    assign wr_dir = wr_en_i && (addr_i == ADDR_W'(DIR_BASE + h));

    gpio_mask_reg #(.W(HALF_W)) u_out (
      .clk_i, .rst_ni, .wr_i(wr_out), .wdata_i(wr_data), .wmask_i(wr_mask),
      .q_o(out_q[h*HALF_W +: HALF_W])
    );
    gpio_mask_reg #(.W(HALF_W)) u_dir (
      .clk_i, .rst_ni, .wr_i(wr_dir), .wdata_i(wr_data), .wmask_i(wr_mask),
      .q_o(dir_q[h*HALF_W +: HALF_W])
    );
  end

  gpio_in_sync #(.W(NUM_PINS)) u_sync (
    .clk_i, .rst_ni, .d_i(pin_i), .q_o(pin_sync)
  );

  always_comb begin
    rdata_o = '0;
    if (rd_en_i) begin
      for (int h = 0; h < NUM_HALVES; h++) begin
        if (addr_i == ADDR_W'(OUT_BASE + h)) rdata_o[HALF_W-1:0] = out_q[h*HALF_W +: HALF_W];
        if (addr_i == ADDR_W'(DIR_BASE + h)) rdata_o[HALF_W-1:0] = dir_q[h*HALF_W +: HALF_W];
      end
      if (addr_i == ADDR_W'(PIN_ADDR)) rdata_o = BUS_W'(pin_sync);
    end
  end

  assign pin_o    = out_q;
  assign pin_oe_o = dir_q;

  // cycles since reset, saturating; qualifies the sync-delay check
  logic [1:0] since_rst_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) since_rst_q <= '0;
    else if (since_rst_q != 2'd2) since_rst_q <= since_rst_q + 2'd1;
  end

  // R9
  idle_rdata_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |-> rdata_o == '0);

  // R6
  half_upper_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && addr_i < ADDR_W'(PIN_ADDR)) |-> rdata_o[BUS_W-1:HALF_W] == '0);

  // R7
  sync_delay_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && addr_i == ADDR_W'(PIN_ADDR) && since_rst_q == 2'd2)
      |-> rdata_o == BUS_W'($past(pin_i, 2)));

  // R8
  dead_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i >= ADDR_W'(PIN_ADDR)) |=> ($stable(pin_o) && $stable(pin_oe_o)));
endmodule

// File: tb/gpio_bank_tb_top.sv
module gpio_bank_tb_top;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        wr_en = 0, rd_en = 0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0, pin_in = '0;
  logic [31:0] rdata, pin_out, pin_oe;
  int total = 0, bad = 0;
  bit done = 0;

  localparam logic [2:0] A_OUT_LO = 3'd0, A_OUT_HI = 3'd1, A_DIR_LO = 3'd2,
                         A_DIR_HI = 3'd3, A_PIN = 3'd4;

  always #5 clk = ~clk;

  gpio_bank dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .pin_i(pin_in), .pin_o(pin_out), .pin_oe_o(pin_oe)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    addr = a; wdata = d; wr_en = 1;
    @(posedge clk); @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd_chk(string req, logic [2:0] a, logic [31:0] exp);
    addr = a; rd_en = 1; #1;
    check(req, rdata, exp);
    @(negedge clk);
    rd_en = 0;
  endtask

  task automatic t_reset;
    check("R1 oe", pin_oe, 32'h0);
    check("R1 out", pin_out, 32'h0);
    rd_chk("R1 out_lo", A_OUT_LO, 32'h0);
    rd_chk("R1 dir_hi", A_DIR_HI, 32'h0);
  endtask

  task automatic t_full;
    wr(A_OUT_LO, 32'hFFFF_A5C3);
    rd_chk("R3 R6 out_lo", A_OUT_LO, 32'h0000_A5C3);
    check("R3 R4 pin_o", pin_out, 32'h0000_A5C3);
  endtask

  task automatic t_masked;
    wr(A_OUT_LO, 32'h00F0_0000);
    rd_chk("R2 clear nibble", A_OUT_LO, 32'h0000_A503);
    wr(A_OUT_LO, 32'h0F00_0F0F);
    rd_chk("R2 set nibble", A_OUT_LO, 32'h0000_AF03);
  endtask

  task automatic t_high;
    wr(A_OUT_HI, 32'hFFFF_1234);
    check("R4 pin_o both halves", pin_out, 32'h1234_AF03);
    rd_chk("R4 low kept", A_OUT_LO, 32'h0000_AF03);
    rd_chk("R6 out_hi", A_OUT_HI, 32'h0000_1234);
  endtask

  task automatic t_dir;
    wr(A_DIR_LO, 32'hFFFF_00FF);
    wr(A_DIR_HI, 32'h8000_FFFF);
    check("R5 oe", pin_oe, 32'h8000_00FF);
    check("R5 out indep of dir", pin_out, 32'h1234_AF03);
    wr(A_DIR_LO, 32'h0000_FFFF);
    check("R2 zero mask", pin_oe, 32'h8000_00FF);
  endtask

  task automatic t_port;
    pin_in = 32'hDEAD_BEEF;
    @(posedge clk); @(negedge clk);
    rd_chk("R7 one edge", A_PIN, 32'h0);
    rd_chk("R7 two edges", A_PIN, 32'hDEAD_BEEF);
  endtask

  task automatic t_ignore;
    wr(A_PIN, 32'hFFFF_FFFF);
    wr(3'd7, 32'hFFFF_FFFF);
    wr(3'd5, 32'hFFFF_0000);
    check("R8 out kept", pin_out, 32'h1234_AF03);
    check("R8 oe kept", pin_oe, 32'h8000_00FF);
    rd_chk("R8 unmapped read", 3'd6, 32'h0);
  endtask

  task automatic t_idle;
    addr = A_OUT_LO; rd_en = 0; #1;
    check("R9 idle", rdata, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_full();
    t_masked();
    t_high();
    t_dir();
    t_port();
    t_ignore();
    t_idle();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule